// File: doc/BRIEF.md
# Cache-Side Transaction Issuer

This block sits between an L1 cache controller and a VCI network. On the request side it accepts three kinds of work. The first is a single-word uncached read. The second is a full cache-line refill for either data or instructions. The third is a flush of one write-buffer slot. For each accepted request it builds the VCI command fields: CMD, address, PLEN, BE, PKTID and TRDID. A read always leaves as one command flit. A write leaves as a burst of one to eight flits, and the block fetches the data and byte enables for each flit from the write buffer through a small lookup port.

On the response side, read flits are steered to a data refill port or an instruction refill port according to the transaction type that comes back in PKTID. A write response pulses an acknowledge for the write-buffer slot named in TRDID. A response that matches no outstanding request raises an error pulse instead. Several transactions may be outstanding at the same time. Each read type code may have one outstanding read, and each write-buffer slot may have one outstanding flush.

Top module: `cacheVciIssuer`

## Requirements
- R1: After reset, cmdVal, both refill valids, every wrSlotAck bit and rspError are low. rdReqReady and wrReqReady are high for a free type or slot.
- R2: A read is sent as one flit with cmdCmd=01, cmdEop=1, cmdTrdid=0, cmdBe all ones and cmdPktid={0,0,type}. In rdReqType, bit0=1 means cached and bit1=1 means instruction.
- R3: An uncached read has cmdPlen=4 and a word-aligned address (low 2 bits cleared). A cached read has cmdPlen=64 and a line-aligned address (low 6 bits cleared).
- R4: While cmdVal is high and cmdAck is low, every command field holds its value. The next flit appears only after the cycle in which cmdAck was high.
- R5: A write is sent with cmdCmd=10, cmdPktid=0100 and cmdTrdid=slot. Flit addresses are consecutive words from the request address. cmdEop is high on the last flit only. Each flit carries the cmdWdata and cmdBe returned for (wrBufSlot, wrBufWord), where wrBufWord is the word index within the line. A zero BE is forwarded unchanged.
- R6: wrReqLen holds the flit count minus one (0..7). The burst is cut short so that it ends at the boundary of its aligned 8-word half line. cmdPlen is the flit count times 4.
- R7: A read whose type code already has an outstanding read is stalled (rdReqReady=0) until a response flit with cmdEop for that type arrives. A flush of a slot that is still outstanding is stalled (wrReqReady=0) until its write response arrives.
- R8: A matching read response with PKTID bit1=0 drives dataRefillValid. With bit1=1 it drives instRefillValid. refillData equals rspRdata, and refillLast equals rspEop, in the same cycle.
- R9: A response with PKTID low bits 100 whose TRDID names an outstanding slot pulses only that bit of wrSlotAck for one cycle.
- R10: rspError pulses for one cycle, with no refill valid and no wrSlotAck, when a response matches nothing outstanding. This covers a type that is not pending, a type code from 101 to 111, a read response with nonzero TRDID, and a write response for a slot that is not pending.
- R11: When a write and a read request are both presented in the same idle cycle, the write is accepted first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdReqValid | input | 1 | Read request present |
| rdReqType | input | 2 | bit0 cached, bit1 instruction |
| rdReqAddr | input | ADDR_W | Read byte address |
| rdReqReady | output | 1 | Read request accepted this cycle if valid |
| wrReqValid | input | 1 | Write-buffer flush request present |
| wrReqSlot | input | SLOT_W | Write-buffer slot to flush |
| wrReqAddr | input | ADDR_W | Byte address of the first word |
| wrReqLen | input | HALF_W | Flit count minus one |
| wrReqReady | output | 1 | Flush request accepted this cycle if valid |
| wrBufSlot | output | SLOT_W | Slot whose word is being fetched |
| wrBufWord | output | LINE_W | Word index within the line being fetched |
| wrBufData | input | DATA_W | Fetched write data |
| wrBufBe | input | DATA_W/8 | Fetched byte enables |
| cmdVal | output | 1 | Command flit valid |
| cmdAck | input | 1 | Command flit taken |
| cmdCmd | output | 2 | 01 read, 10 write |
| cmdAddr | output | ADDR_W | Command byte address |
| cmdPlen | output | PLEN_W | Packet length in bytes |
| cmdBe | output | DATA_W/8 | Byte enables |
| cmdWdata | output | DATA_W | Write data |
| cmdPktid | output | 4 | Transaction type |
| cmdTrdid | output | SLOT_W | Thread id / slot index |
| cmdEop | output | 1 | Last flit of the packet |
| rspVal | input | 1 | Response flit valid |
| rspAck | output | 1 | Response flit taken (always high) |
| rspRdata | input | DATA_W | Response data |
| rspPktid | input | 4 | Response transaction type |
| rspTrdid | input | SLOT_W | Response thread id |
| rspEop | input | 1 | Last response flit |
| dataRefillValid | output | 1 | Flit for the data cache |
| instRefillValid | output | 1 | Flit for the instruction cache |
| refillData | output | DATA_W | Refill word |
| refillLast | output | 1 | Last refill word |
| wrSlotAck | output | SLOTS | Per-slot write completion pulse |
| rspError | output | 1 | Unmatched response pulse |

## Verification
The bench uses the default parameters: 32-bit address and data, a 16-word line and 8 write-buffer slots. With these values a half line is 8 words. A start offset of 6 together with the maximum length shows the clipping at the half-line boundary. Offset 2 with a length of 4 shows a full in-range burst. The 64-byte PLEN and the 16-flit refill of a cached read come out at the defaults, and the slot indices 1, 2 and 5 show that the per-slot acknowledge lands on distinct bits.

// File: rtl/vciIssuerPkg.sv
package vciIssuerPkg;
  localparam logic [1:0] CMD_READ  = 2'b01;
  localparam logic [1:0] CMD_WRITE = 2'b10;
  localparam logic [2:0] TYPE_WRITE = 3'b100;

  typedef struct packed {
    logic loadRd;
    logic loadWr;
    logic advance;
    logic issue;
  } issueStrobe_t;
endpackage

// File: rtl/vciIssuerCtrl.sv
module vciIssuerCtrl
  import vciIssuerPkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdReqValid,
  input  logic [1:0]        rdReqType,
  output logic              rdReqReady,
  input  logic              wrReqValid,
  input  logic [SLOT_W-1:0] wrReqSlot,
  output logic              wrReqReady,
  input  logic              cmdAck,
  input  logic              isLast,
  output issueStrobe_t      strobe,
  input  logic              rspVal,
  input  logic              rspEop,
  input  logic [2:0]        rspType,
  input  logic [SLOT_W-1:0] rspTrdid,
  output logic              dataRefillValid,
  output logic              instRefillValid,
  output logic [SLOTS-1:0]  wrSlotAck,
  output logic              rspError
);
  typedef enum logic [1:0] {IDLE, READCMD, WRITECMD} state_e;
  state_e state;
  logic [3:0]       typeBusy;
  logic [SLOTS-1:0] slotBusy;
  logic idle, wrGo, rdGo, rdHit, wrHit;

  always_comb begin
    idle = (state == IDLE);
    wrGo = idle && wrReqValid && !slotBusy[wrReqSlot];
    rdGo = idle && rdReqValid && !typeBusy[rdReqType] && !wrGo;
    wrReqReady = idle && !slotBusy[wrReqSlot];
    rdReqReady = idle && !typeBusy[rdReqType] && !wrGo;
    strobe.loadWr  = wrGo;
    strobe.loadRd  = rdGo;
    strobe.issue   = (state != IDLE);
    strobe.advance = (state == WRITECMD) && cmdAck && !isLast;
  end

  always_comb begin
    rdHit = rspVal && !rspType[2] && typeBusy[rspType[1:0]] && (rspTrdid == '0);
    wrHit = rspVal && (rspType == TYPE_WRITE) && slotBusy[rspTrdid];
    dataRefillValid = rdHit && !rspType[1];
    instRefillValid = rdHit && rspType[1];
    wrSlotAck = '0;
    if (wrHit) wrSlotAck[rspTrdid] = 1'b1;
    rspError = rspVal && !rdHit && !wrHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= IDLE;
      typeBusy <= '0;
      slotBusy <= '0;
    end else begin
      if (rdGo) typeBusy[rdReqType] <= 1'b1;
      if (rdHit && rspEop) typeBusy[rspType[1:0]] <= 1'b0;
      if (wrGo) slotBusy[wrReqSlot] <= 1'b1;
      if (wrHit) slotBusy[rspTrdid] <= 1'b0;
      case (state)
        IDLE:     if (wrGo) state <= WRITECMD;
                  else if (rdGo) state <= READCMD;
        READCMD:  if (cmdAck) state <= IDLE;
        WRITECMD: if (cmdAck && isLast) state <= IDLE;
        default:  state <= IDLE;
      endcase
    end
  end

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    typeBusy[0] && !(rdHit && rspEop && rspType[1:0] == 2'b00) |=> typeBusy[0]);

  // R10
  err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspError |-> !dataRefillValid && !instRefillValid && (wrSlotAck == '0));
endmodule

// File: rtl/vciIssuerDpath.sv
module vciIssuerDpath
  import vciIssuerPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SLOT_W     = 3,
  parameter int LINE_WORDS = 16,
  localparam int BE_W      = DATA_W / 8,
  localparam int WORD_LSB  = $clog2(BE_W),
  localparam int LINE_W    = $clog2(LINE_WORDS),
  localparam int HALF_WORDS = LINE_WORDS / 2,
  localparam int HALF_W    = $clog2(HALF_WORDS),
  localparam int LINE_LSB  = WORD_LSB + LINE_W,
  localparam int PLEN_W    = $clog2(LINE_WORDS * BE_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  issueStrobe_t      strobe,
  input  logic [1:0]        rdReqType,
  input  logic [ADDR_W-1:0] rdReqAddr,
  input  logic [SLOT_W-1:0] wrReqSlot,
  input  logic [ADDR_W-1:0] wrReqAddr,
  input  logic [HALF_W-1:0] wrReqLen,
  output logic [SLOT_W-1:0] wrBufSlot,
  output logic [LINE_W-1:0] wrBufWord,
  input  logic [DATA_W-1:0] wrBufData,
  input  logic [BE_W-1:0]   wrBufBe,
  input  logic              cmdAck,
  output logic              cmdVal,
  output logic [1:0]        cmdCmd,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [PLEN_W-1:0] cmdPlen,
  output logic [BE_W-1:0]   cmdBe,
  output logic [DATA_W-1:0] cmdWdata,
  output logic [3:0]        cmdPktid,
  output logic [SLOT_W-1:0] cmdTrdid,
  output logic              cmdEop,
  output logic              isLast
);
  logic              isWr;
  logic [1:0]        typeReg;
  logic [SLOT_W-1:0] slotReg;
  logic [ADDR_W-1:0] baseAddr;
  logic [HALF_W-1:0] flitIdx, lastIdx;
  logic [PLEN_W-1:0] plenReg;
  logic [HALF_W:0]   room, want, flits;

  always_comb begin
    room  = (HALF_W+1)'(HALF_WORDS) - {1'b0, wrReqAddr[WORD_LSB +: HALF_W]};
    want  = {1'b0, wrReqLen} + 1'b1;
    flits = (want < room) ? want : room;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isWr <= 1'b0; typeReg <= '0; slotReg <= '0; baseAddr <= '0;
      flitIdx <= '0; lastIdx <= '0; plenReg <= '0;
    end else if (strobe.loadRd) begin
      isWr    <= 1'b0;
      typeReg <= rdReqType;
      slotReg <= '0;
      flitIdx <= '0;
      lastIdx <= '0;
      if (rdReqType[0]) begin
        baseAddr <= {rdReqAddr[ADDR_W-1:LINE_LSB], {LINE_LSB{1'b0}}};
        plenReg  <= PLEN_W'(LINE_WORDS * BE_W);
      end else begin
        baseAddr <= {rdReqAddr[ADDR_W-1:WORD_LSB], {WORD_LSB{1'b0}}};
        plenReg  <= PLEN_W'(BE_W);
      end
    end else if (strobe.loadWr) begin
      isWr     <= 1'b1;
      typeReg  <= '0;
      slotReg  <= wrReqSlot;
      flitIdx  <= '0;
      lastIdx  <= HALF_W'(flits - 1'b1);
      baseAddr <= {wrReqAddr[ADDR_W-1:WORD_LSB], {WORD_LSB{1'b0}}};
      plenReg  <= PLEN_W'(flits) << WORD_LSB;
    end else if (strobe.advance) begin
      flitIdx <= flitIdx + 1'b1;
    end
  end

  always_comb begin
    cmdVal    = strobe.issue;
    cmdAddr   = baseAddr + (ADDR_W'(flitIdx) << WORD_LSB);
    cmdCmd    = isWr ? CMD_WRITE : CMD_READ;
    cmdPlen   = plenReg;
    isLast    = (flitIdx == lastIdx);
    cmdEop    = isLast;
    cmdPktid  = isWr ? {1'b0, TYPE_WRITE} : {2'b00, typeReg};
    cmdTrdid  = isWr ? slotReg : '0;
    cmdBe     = isWr ? wrBufBe : '1;
    cmdWdata  = isWr ? wrBufData : '0;
    wrBufSlot = slotReg;
    wrBufWord = cmdAddr[WORD_LSB +: LINE_W];
  end

  // R4
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdVal && !cmdAck |=> cmdVal && $stable(cmdAddr) && $stable(cmdPktid)
                          && $stable(cmdTrdid) && $stable(cmdEop) && $stable(cmdPlen));

  // R2
  read_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdVal && cmdCmd == CMD_READ |-> cmdEop);

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdVal && cmdCmd == CMD_WRITE && cmdAck && !cmdEop
      |=> cmdVal && cmdAddr == $past(cmdAddr) + ADDR_W'(BE_W));

  // R6
  half_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdVal && cmdCmd == CMD_WRITE && cmdAck && !cmdEop
      |=> cmdAddr[ADDR_W-1:WORD_LSB+HALF_W] == $past(cmdAddr[ADDR_W-1:WORD_LSB+HALF_W]));
endmodule

// File: rtl/cacheVciIssuer.sv
module cacheVciIssuer
  import vciIssuerPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 16,
  parameter int SLOTS      = 8,
  localparam int SLOT_W    = $clog2(SLOTS),
  localparam int BE_W      = DATA_W / 8,
  localparam int LINE_W    = $clog2(LINE_WORDS),
  localparam int HALF_W    = $clog2(LINE_WORDS / 2),
  localparam int PLEN_W    = $clog2(LINE_WORDS * BE_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdReqValid,
  input  logic [1:0]        rdReqType,
  input  logic [ADDR_W-1:0] rdReqAddr,
  output logic              rdReqReady,
  input  logic              wrReqValid,
  input  logic [SLOT_W-1:0] wrReqSlot,
  input  logic [ADDR_W-1:0] wrReqAddr,
  input  logic [HALF_W-1:0] wrReqLen,
  output logic              wrReqReady,
  output logic [SLOT_W-1:0] wrBufSlot,
  output logic [LINE_W-1:0] wrBufWord,
  input  logic [DATA_W-1:0] wrBufData,
  input  logic [BE_W-1:0]   wrBufBe,
  output logic              cmdVal,
  input  logic              cmdAck,
  output logic [1:0]        cmdCmd,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [PLEN_W-1:0] cmdPlen,
  output logic [BE_W-1:0]   cmdBe,
  output logic [DATA_W-1:0] cmdWdata,
  output logic [3:0]        cmdPktid,
  output logic [SLOT_W-1:0] cmdTrdid,
  output logic              cmdEop,
  input  logic              rspVal,
  output logic              rspAck,
  input  logic [DATA_W-1:0] rspRdata,
  input  logic [3:0]        rspPktid,
  input  logic [SLOT_W-1:0] rspTrdid,
  input  logic              rspEop,
  output logic              dataRefillValid,
  output logic              instRefillValid,
  output logic [DATA_W-1:0] refillData,
  output logic              refillLast,
  output logic [SLOTS-1:0]  wrSlotAck,
  output logic              rspError
);
  issueStrobe_t strobe;
  logic isLast;

  assign rspAck     = 1'b1;
  assign refillData = rspRdata;
  assign refillLast = rspEop;

  vciIssuerCtrl #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) ctrl (
    .clk(clk), .rstN(rstN),
    .rdReqValid(rdReqValid), .rdReqType(rdReqType), .rdReqReady(rdReqReady),
    .wrReqValid(wrReqValid), .wrReqSlot(wrReqSlot), .wrReqReady(wrReqReady),
    .cmdAck(cmdAck), .isLast(isLast), .strobe(strobe),
    .rspVal(rspVal), .rspEop(rspEop), .rspType(rspPktid[2:0]), .rspTrdid(rspTrdid),
    .dataRefillValid(dataRefillValid), .instRefillValid(instRefillValid),
    .wrSlotAck(wrSlotAck), .rspError(rspError)
  );

  vciIssuerDpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W),
                   .LINE_WORDS(LINE_WORDS)) dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rdReqType(rdReqType), .rdReqAddr(rdReqAddr),
    .wrReqSlot(wrReqSlot), .wrReqAddr(wrReqAddr), .wrReqLen(wrReqLen),
    .wrBufSlot(wrBufSlot), .wrBufWord(wrBufWord),
    .wrBufData(wrBufData), .wrBufBe(wrBufBe),
    .cmdAck(cmdAck), .cmdVal(cmdVal), .cmdCmd(cmdCmd), .cmdAddr(cmdAddr),
    .cmdPlen(cmdPlen), .cmdBe(cmdBe), .cmdWdata(cmdWdata), .cmdPktid(cmdPktid),
    .cmdTrdid(cmdTrdid), .cmdEop(cmdEop), .isLast(isLast)
  );
endmodule

// File: tb/cacheVciIssuer_test.sv
module cacheVciIssuer_test;
  logic clk = 0, rstN = 0;
  logic rdReqValid = 0, wrReqValid = 0, cmdAck = 0, rspVal = 0, rspEop = 0;
  logic [1:0] rdReqType = 0;
  logic [31:0] rdReqAddr = 0, wrReqAddr = 0, rspRdata = 0;
  logic [2:0] wrReqSlot = 0, wrReqLen = 0, rspTrdid = 0;
  logic [3:0] rspPktid = 0;
  logic rdReqReady, wrReqReady, cmdVal, cmdEop, rspAck;
  logic dataRefillValid, instRefillValid, refillLast, rspError;
  logic [2:0] wrBufSlot, cmdTrdid;
  logic [3:0] wrBufWord, cmdBe, cmdPktid, wrBufBe;
  logic [31:0] wrBufData, cmdAddr, cmdWdata, refillData;
  logic [1:0] cmdCmd;
  logic [6:0] cmdPlen;
  logic [7:0] wrSlotAck;
  logic [3:0] beMap [16];
  int checks = 0, errs = 0;

  always #10 clk = ~clk;

  function automatic logic [31:0] bufData(input logic [2:0] s, input logic [3:0] w);
    return 32'hC0DE0000 | (32'(s) << 8) | 32'(w);
  endfunction
  assign wrBufData = bufData(wrBufSlot, wrBufWord);
  assign wrBufBe   = beMap[wrBufWord];

  cacheVciIssuer uut (.*);

  task automatic chkEq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ackFlit();
    cmdAck = 1; @(negedge clk); cmdAck = 0;
  endtask

  task automatic rspFlit(input logic [3:0] p, input logic [2:0] t, input logic [31:0] d, input logic e);
    rspVal = 1; rspPktid = p; rspTrdid = t; rspRdata = d; rspEop = e; #1;
  endtask

  task automatic testReset();
    #1;
    chkEq("R1 cmdVal", cmdVal, 0);
    chkEq("R1 outputs", {dataRefillValid, instRefillValid, wrSlotAck, rspError}, 0);
    chkEq("R1 ready", {rdReqReady, wrReqReady}, 2'b11);
  endtask

  task automatic testUncached();
    @(negedge clk); rdReqValid = 1; rdReqType = 2'b00; rdReqAddr = 32'h12345677;
    @(negedge clk); rdReqValid = 0; #1;
    chkEq("R2 read cmd", {cmdVal, cmdCmd, cmdEop, cmdPktid, cmdTrdid, cmdBe}, {1'b1, 2'b01, 1'b1, 4'h0, 3'd0, 4'hF});
    chkEq("R3 uncached addr", cmdAddr, 32'h12345674);
    chkEq("R3 uncached plen", cmdPlen, 4);
    @(negedge clk); #1;
    chkEq("R4 held addr", {cmdVal, cmdAddr}, {1'b1, 32'h12345674});
    ackFlit(); #1;
    chkEq("R4 done", cmdVal, 0);
    rspFlit(4'h0, 3'd0, 32'hBEEF0001, 1);
    chkEq("R8 data route", {dataRefillValid, instRefillValid, refillLast, rspError}, 4'b1010);
    chkEq("R8 data word", refillData, 32'hBEEF0001);
    @(negedge clk); rspVal = 0;
  endtask

  task automatic testCachedInst();
    @(negedge clk); rdReqValid = 1; rdReqType = 2'b11; rdReqAddr = 32'h000010C4;
    @(negedge clk); rdReqValid = 0; #1;
    chkEq("R2 inst pktid", cmdPktid, 4'h3);
    chkEq("R3 cached addr", cmdAddr, 32'h000010C0);
    chkEq("R3 cached plen", cmdPlen, 64);
    ackFlit(); rdReqValid = 1; #1;
    chkEq("R7 busy stall", rdReqReady, 0);
    rdReqValid = 0;
    for (int i = 0; i < 16; i++) begin
      rspFlit(4'h3, 3'd0, 32'h100 + i, i == 15);
      chkEq("R8 inst route", {dataRefillValid, instRefillValid, refillLast}, {1'b0, 1'b1, i == 15});
      @(negedge clk); rspVal = 0;
    end
    rdReqValid = 1; #1;
    chkEq("R7 released", rdReqReady, 1);
    rdReqValid = 0;
  endtask

  task automatic testWrite();
    for (int w = 0; w < 16; w++) beMap[w] = 4'hF;
    beMap[3] = 4'h0; beMap[4] = 4'h6;
    @(negedge clk); wrReqValid = 1; wrReqSlot = 3'd5; wrReqAddr = 32'h00002008; wrReqLen = 3'd3;
    #1 chkEq("R1 wr ready", wrReqReady, 1);
    @(negedge clk); wrReqValid = 0;
    for (int i = 0; i < 4; i++) begin
      #1;
      chkEq("R5 wr fields", {cmdVal, cmdCmd, cmdPktid, cmdTrdid, cmdEop}, {1'b1, 2'b10, 4'h4, 3'd5, i == 3});
      chkEq("R5 wr addr", cmdAddr, 32'h2008 + 4 * i);
      chkEq("R5 wr data", {cmdWdata, cmdBe}, {bufData(5, 4'(2 + i)), beMap[2 + i]});
      chkEq("R6 wr plen", cmdPlen, 16);
      if (i == 1) begin
        @(negedge clk); #1;
        chkEq("R4 wr held", {cmdVal, cmdAddr}, {1'b1, 32'h200C});
      end
      ackFlit();
    end
    #1 chkEq("R5 burst end", cmdVal, 0);
    @(negedge clk); wrReqValid = 1; wrReqSlot = 3'd2; wrReqAddr = 32'h00003018; wrReqLen = 3'd7;
    @(negedge clk); wrReqValid = 0;
    for (int i = 0; i < 2; i++) begin
      #1;
      chkEq("R6 clip addr", {cmdAddr, cmdEop, wrBufWord}, {32'h3018 + 4 * i, i == 1, 4'(6 + i)});
      chkEq("R6 clip plen", cmdPlen, 8);
      ackFlit();
    end
    #1 chkEq("R6 clip end", cmdVal, 0);
    wrReqValid = 1; wrReqSlot = 3'd5; #1;
    chkEq("R7 slot stall", wrReqReady, 0);
    wrReqValid = 0;
    @(negedge clk); rspFlit(4'h4, 3'd5, 0, 1);
    chkEq("R9 slot ack", {wrSlotAck, rspError}, {8'h20, 1'b0});
    @(negedge clk); rspFlit(4'h4, 3'd5, 0, 1);
    chkEq("R10 stale wr", {wrSlotAck, rspError}, {8'h00, 1'b1});
    @(negedge clk); rspFlit(4'hC, 3'd2, 0, 1);
    chkEq("R9 slot2 ack", wrSlotAck, 8'h04);
    @(negedge clk); rspVal = 0;
  endtask

  task automatic testErrors();
    @(negedge clk); rspFlit(4'h1, 3'd0, 32'h55, 1);
    chkEq("R10 idle type", {dataRefillValid, instRefillValid, rspError}, 3'b001);
    @(negedge clk); rspFlit(4'h5, 3'd0, 32'h55, 1);
    chkEq("R10 bad code", {dataRefillValid, instRefillValid, wrSlotAck, rspError}, {10'd0, 1'b1});
    @(negedge clk); rspVal = 0;
  endtask

  task automatic testPriority();
    for (int w = 0; w < 16; w++) beMap[w] = 4'hF;
    @(negedge clk); rdReqValid = 1; rdReqType = 2'b00; rdReqAddr = 32'h500;
    wrReqValid = 1; wrReqSlot = 3'd1; wrReqAddr = 32'h4000; wrReqLen = 3'd0; #1;
    chkEq("R11 ready pick", {wrReqReady, rdReqReady}, 2'b10);
    @(negedge clk); wrReqValid = 0; #1;
    chkEq("R11 write first", {cmdVal, cmdCmd, cmdEop, cmdAddr}, {1'b1, 2'b10, 1'b1, 32'h4000});
    ackFlit(); #1;
    chkEq("R11 read next ready", rdReqReady, 1);
    @(negedge clk); rdReqValid = 0; #1;
    chkEq("R11 read issued", {cmdVal, cmdCmd, cmdAddr}, {1'b1, 2'b01, 32'h500});
    ackFlit();
    rspFlit(4'h0, 3'd2, 32'h77, 1);
    chkEq("R10 trdid mismatch", {dataRefillValid, rspError}, 2'b01);
    @(negedge clk); rspFlit(4'h8, 3'd0, 32'h78, 1);
    chkEq("R8 top bit ignored", {dataRefillValid, refillData, rspError}, {1'b1, 32'h78, 1'b0});
    @(negedge clk); rspFlit(4'h4, 3'd1, 0, 1);
    chkEq("R9 slot1 ack", wrSlotAck, 8'h02);
    @(negedge clk); rspVal = 0;
  endtask

  initial begin
    for (int w = 0; w < 16; w++) beMap[w] = 4'hF;
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testUncached();
    testCachedInst();
    testWrite();
    testErrors();
    testPriority();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++; errs++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule